// File: doc/BRIEF.md
# AC-Capable Output Boundary-Scan Cell

This block is one boundary-scan register cell placed in front of an output pin driver. It holds a capture/shift flip-flop and an update flip-flop on the serial scan path, so a test value can be shifted in, copied to the update stage and driven out of the pin. The cell supports two test styles. In static test, the pin shows the update level unchanged. In AC test, the update level is exclusive-ORed with a toggle signal supplied by the TAP, so the pin produces the edges that an AC-coupled link needs. A per-cell AC/DC select input can suppress that toggle, and a driver-enable input from a control cell can put the driver into high impedance. When the cell is not in test, the mission data and mission enable pass straight through. A build option adds a complementary minus leg for differential pins.

The TAP state machine and the analog driver are outside the block. The TAP provides decoded strobes (capture, shift, update, instruction load, test-logic-reset) and the AC toggle. A small drive-mode state machine records which kind of instruction is in effect. It has three states. ST_MISSION passes mission data through. ST_STATIC drives the update level. ST_AC drives the update level XOR the gated toggle. The state machine makes these transitions on a falling clock edge:
- from any state to ST_MISSION when test-logic-reset is asserted;
- on an instruction load, to the state given by the instruction code.

Top module: `ac_bscan_out_cell`

## Requirements
- R1: After reset, after a falling edge with `tlr` high, and while the mode is mission (instruction code 2'b00 or 2'b11), `pad_p` equals `sys_data` and `pad_oe` equals `sys_oe`.
- R2: On a rising `tck` edge with `capture_dr` high, the shift stage loads the value currently on `pad_p`. When parameter CAPT_FIXED is 1, it loads the constant CAPT_VAL instead. Capture takes priority over shift.
- R3: On a rising `tck` edge with `shift_dr` high and `capture_dr` low, the shift stage loads `tdi`. `tdo` always shows the shift stage.
- R4: The update stage loads the shift stage on a falling `tck` edge with `update_dr` high, and holds its value otherwise. Shifting does not disturb the pin.
- R5: On a falling edge with `ir_load` high and `tlr` low, the drive mode is set from `instr`: 2'b01 selects static test, 2'b10 selects AC test, and 2'b00 or 2'b11 select mission.
- R6: In static test with `drv_en` high, `pad_p` equals the update level whatever `ac_toggle` and `acdc_sel` are, and `pad_oe` is 1.
- R7: In AC test with `acdc_sel` = 1, `pad_p` equals the update level XOR `ac_toggle`.
- R8: In AC test with `acdc_sel` = 0, `pad_p` equals the update level and `ac_toggle` has no effect.
- R9: In either test mode, `drv_en` = 0 forces `pad_oe` to 0 (not driven). In mission, `drv_en` has no effect on `pad_oe`.
- R10: With DIFF = 1, `pad_n` is always the complement of `pad_p`. With DIFF = 0, `pad_n` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | TAP in test-logic-reset |
| ir_load | input | 1 | Instruction update strobe (falling edge) |
| instr | input | 2 | Decoded instruction class |
| capture_dr | input | 1 | Capture strobe (rising edge) |
| shift_dr | input | 1 | Shift strobe (rising edge) |
| update_dr | input | 1 | Update strobe (falling edge) |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| ac_toggle | input | 1 | AC test toggle from the TAP |
| acdc_sel | input | 1 | AC/DC select from its selection cell (1 = AC) |
| drv_en | input | 1 | Driver enable from its control cell |
| sys_data | input | 1 | Mission output data |
| sys_oe | input | 1 | Mission output enable |
| pad_p | output | 1 | Data to the driver, plus leg |
| pad_n | output | 1 | Data to the driver, minus leg |
| pad_oe | output | 1 | Driver enable |

## Verification
The assertions assume that `tlr` stays high through the falling edge that follows the rising edge where it was first seen. They also assume that the strobes change only between edges, never at an edge. The stimulus changes every input just after a falling edge and holds it for one full period, so the rising-edge stage and the falling-edge stage both see one stable value. Each table row loads an instruction, shifts and updates one bit, and then sets the combinational controls. This keeps the update level known before the pin is checked.

// File: rtl/ac_bscan_pkg.sv
package ac_bscan_pkg;
    localparam int INSTR_W = 2;

    typedef enum logic [1:0] {
        ST_MISSION = 2'd0,
        ST_STATIC  = 2'd1,
        ST_AC      = 2'd2
    } drive_state_e;

    localparam logic [INSTR_W-1:0] CODE_MISSION = 2'b00;
    localparam logic [INSTR_W-1:0] CODE_STATIC  = 2'b01;
    localparam logic [INSTR_W-1:0] CODE_AC      = 2'b10;
    localparam logic [INSTR_W-1:0] CODE_SPARE   = 2'b11;
endpackage

// File: rtl/bsc_shift_stage.sv
module bsc_shift_stage #(
    parameter bit CAPT_FIXED = 1'b0,
    parameter bit CAPT_VAL   = 1'b0
) (
    input  logic tck,
    input  logic rst_n,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    input  logic pin_obs,
    output logic shift_q
);
    logic capt_src;

    generate
        if (CAPT_FIXED) begin : g_const
            assign capt_src = CAPT_VAL;
        end else begin : g_pin
            assign capt_src = pin_obs;
        end
    endgenerate

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= 1'b0;
        end else if (capture_dr) begin
            shift_q <= capt_src;
        end else if (shift_dr) begin
            shift_q <= tdi;
        end
    end

    AST_SHIFT_TAKES_TDI: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> (shift_q == $past(tdi))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
        (!shift_dr && !capture_dr) |=> $stable(shift_q)); // R3
endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic update_dr,
    input  logic shift_q,
    output logic upd_q
);
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else if (update_dr) begin
            upd_q <= shift_q;
        end
    end

    AST_UPDATE_HOLDS: assert property (@(negedge tck) disable iff (!rst_n)
        !update_dr |=> $stable(upd_q)); // R4
endmodule

// File: rtl/bsc_mode_fsm.sv
module bsc_mode_fsm
    import ac_bscan_pkg::*;
(
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tlr,
    input  logic               ir_load,
    input  logic [INSTR_W-1:0] instr,
    output drive_state_e       state,
    output logic               in_test,
    output logic               in_ac
);
    drive_state_e state_q;
    drive_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (tlr) begin
            state_d = ST_MISSION;
        end else if (ir_load) begin
            unique case (instr)
                CODE_STATIC:  state_d = ST_STATIC;
                CODE_AC:      state_d = ST_AC;
                CODE_MISSION: state_d = ST_MISSION;
                CODE_SPARE:   state_d = ST_MISSION;
                default:      state_d = ST_MISSION;
            endcase
        end
    end

    // state register
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MISSION;
        end else begin
            state_q <= state_d;
        end
    end

    // state outputs
    always_comb begin
        in_test = 1'b0;
        in_ac   = 1'b0;
        unique case (state_q)
            ST_MISSION: begin
                in_test = 1'b0;
                in_ac   = 1'b0;
            end
            ST_STATIC: begin
                in_test = 1'b1;
                in_ac   = 1'b0;
            end
            ST_AC: begin
                in_test = 1'b1;
                in_ac   = 1'b1;
            end
            default: begin
                in_test = 1'b0;
                in_ac   = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    AST_TLR_TO_MISSION: assert property (@(posedge tck) disable iff (!rst_n)
        tlr |=> (state_q == ST_MISSION)); // R1

    AST_LOAD_STATIC: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_load && !tlr && instr == CODE_STATIC) |=> (state_q == ST_STATIC)); // R5

    AST_LOAD_AC: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_load && !tlr && instr == CODE_AC) |=> (state_q == ST_AC)); // R5
endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux
    import ac_bscan_pkg::*;
#(
    parameter bit DIFF = 1'b1
) (
    input  logic in_test,
    input  logic in_ac,
    input  logic upd_q,
    input  logic ac_toggle,
    input  logic acdc_sel,
    input  logic drv_en,
    input  logic sys_data,
    input  logic sys_oe,
    output logic pad_p,
    output logic pad_n,
    output logic pad_oe
);
    logic ac_gate;
    logic test_data;

    always_comb begin
        ac_gate   = in_ac & acdc_sel & ac_toggle;
        test_data = upd_q ^ ac_gate;
        if (in_test) begin
            pad_p  = test_data;
            pad_oe = drv_en;
        end else begin
            pad_p  = sys_data;
            pad_oe = sys_oe;
        end
    end

    generate
        if (DIFF) begin : g_diff
            assign pad_n = ~pad_p;
        end else begin : g_single
            assign pad_n = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ac_bscan_out_cell.sv
module ac_bscan_out_cell
    import ac_bscan_pkg::*;
#(
    parameter bit DIFF       = 1'b1,
    parameter bit CAPT_FIXED = 1'b0,
    parameter bit CAPT_VAL   = 1'b0
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tlr,
    input  logic               ir_load,
    input  logic [INSTR_W-1:0] instr,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    input  logic               ac_toggle,
    input  logic               acdc_sel,
    input  logic               drv_en,
    input  logic               sys_data,
    input  logic               sys_oe,
    output logic               pad_p,
    output logic               pad_n,
    output logic               pad_oe
);
    logic         shift_q;
    logic         upd_q;
    logic         in_test;
    logic         in_ac;
    drive_state_e state;

    bsc_shift_stage #(.CAPT_FIXED(CAPT_FIXED), .CAPT_VAL(CAPT_VAL)) u_shift (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .tdi(tdi), .pin_obs(pad_p), .shift_q(shift_q)
    );

    bsc_update_stage u_update (
        .tck(tck), .rst_n(rst_n), .update_dr(update_dr),
        .shift_q(shift_q), .upd_q(upd_q)
    );

    bsc_mode_fsm u_fsm (
        .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_load(ir_load), .instr(instr),
        .state(state), .in_test(in_test), .in_ac(in_ac)
    );

    bsc_pad_mux #(.DIFF(DIFF)) u_mux (
        .in_test(in_test), .in_ac(in_ac), .upd_q(upd_q), .ac_toggle(ac_toggle),
        .acdc_sel(acdc_sel), .drv_en(drv_en), .sys_data(sys_data), .sys_oe(sys_oe),
        .pad_p(pad_p), .pad_n(pad_n), .pad_oe(pad_oe)
    );

    assign tdo = shift_q;

    AST_MISSION_PASS: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_MISSION) |-> (pad_p == sys_data && pad_oe == sys_oe)); // R1

    AST_STATIC_LEVEL: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_STATIC) |-> (pad_p == upd_q)); // R6

    AST_AC_TOGGLES: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_AC && acdc_sel) |-> (pad_p == (upd_q ^ ac_toggle))); // R7

    AST_DC_SELECT_FIXED: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_AC && !acdc_sel) |-> (pad_p == upd_q)); // R8

    AST_DISABLED_HIZ: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_MISSION && !drv_en) |-> !pad_oe); // R9

    generate
        if (DIFF) begin : g_diff_chk
            AST_LEGS_COMPLEMENT: assert property (@(posedge tck) disable iff (!rst_n)
                pad_n == ~pad_p); // R10
        end
    endgenerate
endmodule

// File: tb/tb_ac_bscan_out_cell.sv
module tb_ac_bscan_out_cell;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tlr = 1'b0, ir_load = 1'b0;
    logic [1:0] instr = 2'b00;
    logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic       ac_toggle = 1'b0, acdc_sel = 1'b0, drv_en = 1'b0;
    logic       sys_data = 1'b0, sys_oe = 1'b0;
    logic       tdo, pad_p, pad_n, pad_oe;
    logic       tdo_k, pad_p_k, pad_n_k, pad_oe_k;

    int nvec = 0;
    int nfail = 0;

    always #4 tck = ~tck; // 125 MHz

    ac_bscan_out_cell #(.DIFF(1'b1), .CAPT_FIXED(1'b0), .CAPT_VAL(1'b0)) dut (
        .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_load(ir_load), .instr(instr),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .ac_toggle(ac_toggle), .acdc_sel(acdc_sel),
        .drv_en(drv_en), .sys_data(sys_data), .sys_oe(sys_oe),
        .pad_p(pad_p), .pad_n(pad_n), .pad_oe(pad_oe)
    );

    // variant: single-ended, captures constant 1
    ac_bscan_out_cell #(.DIFF(1'b0), .CAPT_FIXED(1'b1), .CAPT_VAL(1'b1)) dut_k (
        .tck(tck), .rst_n(rst_n), .tlr(tlr), .ir_load(ir_load), .instr(instr),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo_k), .ac_toggle(ac_toggle), .acdc_sel(acdc_sel),
        .drv_en(drv_en), .sys_data(sys_data), .sys_oe(sys_oe),
        .pad_p(pad_p_k), .pad_n(pad_n_k), .pad_oe(pad_oe_k)
    );

    // {instr[1:0], bit, acdc, toggle, en, sys_d, sys_oe, exp_p, exp_oe}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        10'b00_0_1_1_1_1_1_1_1, // R1 mission
        10'b00_1_0_0_0_0_0_0_0, // R1 mission
        10'b11_1_1_1_1_0_1_0_1, // R1 spare code = mission
        10'b01_1_1_1_1_0_0_1_1, // R6 static ignores toggle
        10'b01_0_1_0_1_1_1_0_1, // R6
        10'b10_0_1_1_1_0_0_1_1, // R7
        10'b10_1_1_1_1_0_0_0_1, // R7
        10'b10_1_1_0_1_0_0_1_1, // R7
        10'b10_0_0_1_1_0_0_0_1, // R8
        10'b10_1_0_1_1_0_0_1_1, // R8
        10'b01_1_1_0_0_0_0_1_0, // R9
        10'b10_0_1_1_0_0_0_1_0  // R9
    };

    task automatic check(input string req, input logic got, input logic exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge tck);
        #1;
    endtask

    task automatic load_instr(input logic [1:0] code);
        instr = code; ir_load = 1'b1;
        step();
        ir_load = 1'b0;
    endtask

    task automatic shift_bit(input logic b);
        tdi = b; shift_dr = 1'b1;
        step();
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
    endtask

    function automatic string req_of(input logic [1:0] code, input logic a, input logic en);
        if (code == 2'b00 || code == 2'b11) return "R1";
        if (!en) return "R9";
        if (code == 2'b01) return "R6";
        if (a) return "R7";
        return "R8";
    endfunction

    initial begin
        #200000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        sys_data = 1'b1; sys_oe = 1'b1; drv_en = 1'b0;
        repeat (3) step();
        // reset state: mission pass-through (R1)
        check("R1 reset pad_p", pad_p, 1'b1);
        check("R1 reset pad_oe", pad_oe, 1'b1);
        check("R3 reset tdo", tdo, 1'b0);
        rst_n = 1'b1;
        step();

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            string r;
            v = VEC[i];
            r = req_of(v[9:8], v[6], v[4]);
            load_instr(v[9:8]);
            shift_bit(v[7]);
            do_update();
            acdc_sel = v[6]; ac_toggle = v[5]; drv_en = v[4];
            sys_data = v[3]; sys_oe = v[2];
            #1;
            check(r, pad_p, v[1]);
            check(r, pad_oe, v[0]);
            check("R10 minus leg", pad_n, ~v[1]);
            check("R10 single-ended minus", pad_n_k, 1'b0);
        end

        // R5: explicit mode loading
        drv_en = 1'b1; sys_data = 1'b0; sys_oe = 1'b0; acdc_sel = 1'b1; ac_toggle = 1'b1;
        load_instr(2'b01);
        shift_bit(1'b1); do_update();
        check("R5 static mode", pad_p, 1'b1);
        load_instr(2'b10);
        check("R5 ac mode", pad_p, 1'b0);
        load_instr(2'b00);
        check("R5 mission mode", pad_p, 1'b0);

        // R3: serial path
        shift_bit(1'b1);
        check("R3 tdo after 1", tdo, 1'b1);
        shift_bit(1'b0);
        check("R3 tdo after 0", tdo, 1'b0);
        step();
        check("R3 tdo holds", tdo, 1'b0);

        // R4: shift does not move the pin; update lands on falling edge
        load_instr(2'b01);
        shift_bit(1'b1); do_update();
        shift_bit(1'b0);
        check("R4 pin held during shift", pad_p, 1'b1);
        step();
        check("R4 pin held without update", pad_p, 1'b1);
        do_update();
        check("R4 update applied", pad_p, 1'b0);

        // R2: capture pad value (static, upd 0) and fixed-constant variant
        shift_bit(1'b1);
        do_capture();
        check("R2 capture static pin", tdo, 1'b0);
        check("R2 capture fixed const", tdo_k, 1'b1);
        // AC mode: upd 1 xor toggle 1 -> 0 captured; capture beats shift
        shift_bit(1'b1); do_update();
        load_instr(2'b10);
        acdc_sel = 1'b1; ac_toggle = 1'b1;
        tdi = 1'b1; shift_dr = 1'b1;
        do_capture();
        shift_dr = 1'b0;
        check("R2 capture ac pin", tdo, 1'b0);

        // R9: enable ignored in mission
        load_instr(2'b00);
        drv_en = 1'b0; sys_oe = 1'b1;
        #1;
        check("R9 mission ignores drv_en", pad_oe, 1'b1);

        // R1: test-logic-reset returns to mission
        load_instr(2'b01);
        sys_data = 1'b0;
        tlr = 1'b1; ir_load = 1'b1; instr = 2'b10;
        step();
        tlr = 1'b0; ir_load = 1'b0;
        check("R1 tlr mission data", pad_p, 1'b0);
        check("R1 tlr mission oe", pad_oe, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule